// File: doc/BRIEF.md
# Temporal Interval Controller

This block keeps a timed ordering between two points of an interactive score. A start pulse opens an interval with a lower bound and an upper bound, both counted in score ticks. The end event cannot fire before the lower bound has run out. Once it has, an external interaction trigger may release the end event at any moment, and the end event is forced when the upper bound runs out. The score tick comes from an internal divider on the system clock. The divider advances only while the tick enable input is high, so the surrounding logic can pause score time.

A start pulse that arrives while the lower bound is still running narrows the window. It raises the remaining lower bound to the new request if the request is larger, and it lowers the remaining upper bound to the new request if the request is smaller. An all-ones upper bound means the interval has no upper limit, so only the trigger can end it. A kill input aborts the interval from any live state. It wins over every other condition in the same cycle.

Top module: `tr_interval_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `state_o` is 0 (idle) and both `end_o` and `killed_o` are low. The state codes are 0 idle, 1 new, 2 wait-min, 3 wait-max, 4 update, 5 done and 6 stop.
- R2: The divider gives exactly one score tick for every TICK_DIV clock cycles in which `tick_en_i` is high. While `tick_en_i` is low, the divider keeps its count and no tick occurs.
- R3: In idle, a start pulse loads the lower timer from `min_dly_i` and the upper timer from `max_dly_i`. The state goes to new for one cycle and then to wait-min. Both timers count down by one on each score tick and stop at zero.
- R4: In wait-min, when the lower timer has reached zero and the upper timer has not, the state moves to wait-max.
- R5: In wait-max, a high `trig_i` or an upper timer at zero produces the end pulse and moves the state to done. A start pulse in wait-max is ignored.
- R6: In wait-min, `trig_i` has no effect and is not remembered for later.
- R7: In wait-min, an upper timer at zero moves the state to stop. If the lower timer is zero in that same cycle, `end_o` and `killed_o` pulse together. Otherwise neither output pulses.
- R8: In wait-min, a start pulse moves the state to update for one cycle and then back to wait-min. In update, the lower timer becomes the larger of its remaining value and `min_dly_i`, and the upper timer becomes the smaller of its remaining value and `max_dly_i`. The delay inputs must stay valid through the update cycle.
- R9: In every state except stop, a high `kill_i` moves the state to stop and pulses `killed_o` with no end pulse. This takes priority over timeouts, the trigger and start.
- R10: An all-ones `max_dly_i` never expires. The interval then stays in wait-max until the trigger arrives.
- R11: `end_o` and `killed_o` are one-cycle pulses. Done and stop are left only by reset or, from done, by kill. Start has no effect in either state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Lets the score tick divider advance |
| start_i | input | 1 | Start event: opens the interval or narrows it |
| trig_i | input | 1 | External interaction trigger |
| kill_i | input | 1 | Abort the interval |
| min_dly_i | input | DLY_W | Requested lower bound, in score ticks |
| max_dly_i | input | DLY_W | Requested upper bound, in score ticks; all ones means no upper limit |
| end_o | output | 1 | One-cycle end event |
| killed_o | output | 1 | One-cycle abort indication |
| state_o | output | 3 | Current state code |

## Verification
The pair of functions that can fall in the same cycle is lower-bound expiry and upper-bound expiry. This happens whenever both bounds are equal, including zero. The sweep runs every lower bound from 0 to 4 against every upper bound from 0 to 5, plus the unlimited value. Each case is judged by its final state, by the number of end and abort pulses, and by the tick on which the end pulse fell, all computed from the two bounds. A second collision is a kill driven in the same cycle as the interaction trigger in wait-max; the bench expects stop with no end pulse.

// File: rtl/tr_pkg.sv
package tr_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_NEW      = 3'd1,
        S_WAIT_MIN = 3'd2,
        S_WAIT_MAX = 3'd3,
        S_UPDATE   = 3'd4,
        S_DONE     = 3'd5,
        S_STOP     = 3'd6
    } tr_state_e;

    localparam int STATE_W = 3;

    // Command from the sequencer to both countdown timers.
    typedef struct packed {
        logic run;          // timers may count on a tick
        logic load_fresh;   // take the requested value as is
        logic load_narrow;  // combine the request with the remaining value
    } tr_ctl_t;

    function automatic logic is_terminal(tr_state_e s);
        return (s == S_DONE) || (s == S_STOP);
    endfunction

endpackage

// File: rtl/tr_tick_gen.sv
module tr_tick_gen #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);  // R2
        end
    endgenerate

    AST_TICK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !tick_o);  // R2

endmodule

// File: rtl/tr_countdown.sv
module tr_countdown
    import tr_pkg::*;
#(
    parameter int W        = 16,
    parameter bit IS_UPPER = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  tr_ctl_t      ctl_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);
    localparam logic [W-1:0] INF = '1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] dec_v;
    logic [W-1:0] narrowed;
    logic         hold_inf;

    generate
        if (IS_UPPER) begin : g_upper
            assign hold_inf = (cnt_q == INF);
            assign narrowed = (val_i < dec_v) ? val_i : dec_v;

            AST_UPPER_SHRINKS: assert property (@(posedge clk) disable iff (rst)
                ctl_i.load_narrow |=> cnt_q <= $past(cnt_q));  // R8
            AST_INF_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (cnt_q == INF && !ctl_i.load_fresh && !ctl_i.load_narrow)
                |=> cnt_q == INF);  // R10
        end else begin : g_lower
            assign hold_inf = 1'b0;
            assign narrowed = (val_i > dec_v) ? val_i : dec_v;

            AST_LOWER_GROWS: assert property (@(posedge clk) disable iff (rst)
                ctl_i.load_narrow |=> cnt_q >= $past(val_i));  // R8
        end
    endgenerate

    assign dec_v = (ctl_i.run && tick_i && (cnt_q != '0) && !hold_inf)
                 ? cnt_q - 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl_i.load_fresh) begin
            cnt_q <= val_i;
        end else if (ctl_i.load_narrow) begin
            cnt_q <= narrowed;
        end else begin
            cnt_q <= dec_v;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.load_fresh && !ctl_i.load_narrow) |=>
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1));  // R3

endmodule

// File: rtl/tr_fsm.sv
module tr_fsm
    import tr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      trig_i,
    input  logic      kill_i,
    input  logic      min_zero_i,
    input  logic      max_zero_i,
    output tr_ctl_t   ctl_o,
    output tr_state_e state_o,
    output logic      end_o,
    output logic      killed_o
);
    tr_state_e st_q, st_n;
    logic      end_q, end_n;
    logic      killed_q, killed_n;
    tr_ctl_t   ctl;

    always_comb begin
        st_n     = st_q;
        end_n    = 1'b0;
        killed_n = 1'b0;
        ctl      = '0;
        if (kill_i && st_q != S_STOP) begin
            st_n     = S_STOP;
            killed_n = 1'b1;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (start_i) begin
                        ctl.load_fresh = 1'b1;
                        st_n           = S_NEW;
                    end
                end
                S_NEW: begin
                    ctl.run = 1'b1;
                    st_n    = S_WAIT_MIN;
                end
                S_WAIT_MIN: begin
                    ctl.run = 1'b1;
                    if (max_zero_i) begin
                        st_n     = S_STOP;
                        end_n    = min_zero_i;
                        killed_n = min_zero_i;
                    end else if (min_zero_i) begin
                        st_n = S_WAIT_MAX;
                    end else if (start_i) begin
                        st_n = S_UPDATE;
                    end
                end
                S_UPDATE: begin
                    ctl.run         = 1'b1;
                    ctl.load_narrow = 1'b1;
                    st_n            = S_WAIT_MIN;
                end
                S_WAIT_MAX: begin
                    ctl.run = 1'b1;
                    if (trig_i || max_zero_i) begin
                        end_n = 1'b1;
                        st_n  = S_DONE;
                    end
                end
                S_DONE, S_STOP: begin
                    st_n = st_q;
                end
                default: st_n = S_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            end_q    <= 1'b0;
            killed_q <= 1'b0;
        end else begin
            st_q     <= st_n;
            end_q    <= end_n;
            killed_q <= killed_n;
        end
    end

    assign ctl_o    = ctl;
    assign state_o  = st_q;
    assign end_o    = end_q;
    assign killed_o = killed_q;

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        end_q |=> !end_q);  // R11
    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
        st_q == S_STOP |=> st_q == S_STOP);  // R11
    AST_DONE_EXIT: assert property (@(posedge clk) disable iff (rst)
        st_q == S_DONE |=> is_terminal(st_q));  // R11
    AST_KILL_WINS: assert property (@(posedge clk) disable iff (rst)
        (kill_i && st_q != S_STOP) |=> (st_q == S_STOP && killed_q && !end_q));  // R9
    AST_WAITMIN_NO_END: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WAIT_MIN && !max_zero_i) |=> !end_q);  // R6
    AST_NEW_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_NEW && !kill_i) |=> st_q == S_WAIT_MIN);  // R3

endmodule

// File: rtl/tr_interval_ctrl.sv
module tr_interval_ctrl
    import tr_pkg::*;
#(
    parameter int DLY_W    = 16,
    parameter int TICK_DIV = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en_i,
    input  logic               start_i,
    input  logic               trig_i,
    input  logic               kill_i,
    input  logic [DLY_W-1:0]   min_dly_i,
    input  logic [DLY_W-1:0]   max_dly_i,
    output logic               end_o,
    output logic               killed_o,
    output logic [STATE_W-1:0] state_o
);
    logic       tick;
    tr_ctl_t    ctl;
    tr_state_e  st;
    logic       min_zero, max_zero;
    logic [DLY_W-1:0] min_cnt, max_cnt;

    tr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en_i   (tick_en_i),
        .tick_o (tick)
    );

    tr_countdown #(.W(DLY_W), .IS_UPPER(1'b0)) u_lower (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .ctl_i  (ctl),
        .val_i  (min_dly_i),
        .cnt_o  (min_cnt),
        .zero_o (min_zero)
    );

    tr_countdown #(.W(DLY_W), .IS_UPPER(1'b1)) u_upper (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .ctl_i  (ctl),
        .val_i  (max_dly_i),
        .cnt_o  (max_cnt),
        .zero_o (max_zero)
    );

    tr_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .trig_i     (trig_i),
        .kill_i     (kill_i),
        .min_zero_i (min_zero),
        .max_zero_i (max_zero),
        .ctl_o      (ctl),
        .state_o    (st),
        .end_o      (end_o),
        .killed_o   (killed_o)
    );

    assign state_o = st;

    AST_WAITMAX_LOWER_DONE: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT_MAX) |-> (min_cnt == '0));  // R4
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == S_WAIT_MAX && st == S_DONE) |-> $past(trig_i || max_cnt == '0));  // R5

endmodule

// File: tb/test_tr_interval_ctrl.sv
module test_tr_interval_ctrl;
    localparam int W   = 4;
    localparam int DIV = 20;
    localparam logic [W-1:0] INF = '1;
    localparam int S_IDLE = 0, S_NEW = 1, S_WMIN = 2, S_WMAX = 3,
                   S_UPD = 4, S_DONE = 5, S_STOP = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, tick_en, start, trig, kill;
    logic [W-1:0] dmin, dmax;
    logic end_o, killed_o;
    logic [2:0] state;

    int n_chk = 0, n_bad = 0;
    int end_cnt, kill_cnt, end_tick, cur_tick;

    tr_interval_ctrl #(.DLY_W(W), .TICK_DIV(DIV)) i_tr_interval_ctrl (
        .clk(clk), .rst(rst), .tick_en_i(tick_en), .start_i(start),
        .trig_i(trig), .kill_i(kill), .min_dly_i(dmin), .max_dly_i(dmax),
        .end_o(end_o), .killed_o(killed_o), .state_o(state)
    );

    always @(negedge clk) begin
        if (end_o) begin end_cnt++; end_tick = cur_tick; end
        if (killed_o) kill_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset;
        rst = 1'b1; start = 0; trig = 0; kill = 0; tick_en = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        end_cnt = 0; kill_cnt = 0; end_tick = -1; cur_tick = 0;
        @(negedge clk);
    endtask

    task automatic go(input logic [W-1:0] mn, input logic [W-1:0] mx);
        dmin = mn; dmax = mx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic restart(input logic [W-1:0] mn, input logic [W-1:0] mx);
        dmin = mn; dmax = mx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic step;
        cur_tick++;
        tick_en = 1'b1;
        repeat (DIV) @(negedge clk);
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_trig;
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_kill;
        kill = 1'b1; @(negedge clk); kill = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        dmin = '0; dmax = '0;
        do_reset();
        chk("R1 state", int'(state), S_IDLE);
        chk("R1 end", int'(end_o), 0);
        chk("R1 killed", int'(killed_o), 0);

        // Sweep of lower against upper bound.
        for (int m = 0; m <= 4; m++) begin
            for (int mi = 0; mi <= 6; mi++) begin
                int mx;
                mx = (mi == 6) ? int'(INF) : mi;
                do_reset();
                go(W'(m), W'(mx));
                if (m == 0) chk("R4/R7 start", int'(state), (mx == 0) ? S_STOP : S_WMAX);
                if (m >= 1 && mx >= 1) begin
                    chk("R3 in wait-min", int'(state), S_WMIN);
                    pulse_trig();
                    chk("R6 trig ignored state", int'(state), S_WMIN);
                    chk("R6 trig ignored end", end_cnt, 0);
                end
                if (mx == int'(INF)) begin
                    repeat (m + 3) step();
                    chk("R10 no expiry state", int'(state), S_WMAX);
                    chk("R10 no expiry end", end_cnt, 0);
                    pulse_trig();
                    chk("R5 trig state", int'(state), S_DONE);
                    chk("R5 trig end", end_cnt, 1);
                    chk("R5 trig killed", kill_cnt, 0);
                end else begin
                    int last;
                    last = ((m > mx) ? m : mx) + 2;
                    for (int k = 1; k <= last; k++) begin
                        step();
                        if (k == m && mx > m) chk("R4 lower expiry", int'(state), S_WMAX);
                    end
                    if (mx > m) begin
                        chk("R5 upper expiry state", int'(state), S_DONE);
                        chk("R5 end count", end_cnt, 1);
                        chk("R5 end tick", end_tick, mx);
                        chk("R5 killed", kill_cnt, 0);
                        restart(W'(1), W'(2));
                        repeat (3) @(negedge clk);
                        chk("R11 start in done", int'(state), S_DONE);
                        chk("R11 single end", end_cnt, 1);
                    end else if (mx == m) begin
                        chk("R7 coincide state", int'(state), S_STOP);
                        chk("R7 coincide end", end_cnt, 1);
                        chk("R7 coincide killed", kill_cnt, 1);
                        chk("R7 coincide tick", end_tick, mx);
                    end else begin
                        chk("R7 early upper state", int'(state), S_STOP);
                        chk("R7 early upper end", end_cnt, 0);
                        chk("R7 early upper killed", kill_cnt, 0);
                    end
                end
            end
        end

        // Divider: DIV-1 enabled cycles give no tick, the next one does.
        do_reset();
        go(W'(1), W'(3));
        tick_en = 1'b1;
        repeat (DIV - 1) @(negedge clk);
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 no early tick", int'(state), S_WMIN);
        repeat (10) @(negedge clk);
        chk("R2 frozen", int'(state), S_WMIN);
        tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 tick on count", int'(state), S_WMAX);

        // Narrowing to a tighter window.
        do_reset();
        go(W'(5), W'(10));
        step(); step();
        restart(W'(4), W'(6));
        chk("R8 update state", int'(state), S_UPD);
        @(negedge clk);
        chk("R8 back to wait-min", int'(state), S_WMIN);
        repeat (2) @(negedge clk);
        repeat (3) step();
        chk("R8 raised lower", int'(state), S_WMIN);
        step();
        chk("R8 raised lower expiry", int'(state), S_WMAX);
        restart(W'(0), W'(0));
        repeat (3) @(negedge clk);
        chk("R5 start in wait-max", int'(state), S_WMAX);
        step(); step();
        chk("R8 lowered upper state", int'(state), S_DONE);
        chk("R8 lowered upper tick", end_tick, 8);

        // Narrowing with looser requests keeps the old bounds.
        do_reset();
        go(W'(5), W'(10));
        step(); step();
        restart(W'(1), W'(12));
        repeat (3) @(negedge clk);
        step(); step();
        chk("R8 kept lower", int'(state), S_WMIN);
        step();
        chk("R8 kept lower expiry", int'(state), S_WMAX);
        repeat (5) step();
        chk("R8 kept upper tick", end_tick, 10);

        // Kill in each state.
        do_reset();
        pulse_kill();
        chk("R9 kill idle", int'(state), S_STOP);
        chk("R9 kill idle pulse", kill_cnt, 1);

        do_reset();
        dmin = 3; dmax = 6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3 new state", int'(state), S_NEW);
        pulse_kill();
        chk("R9 kill new", int'(state), S_STOP);
        chk("R9 kill new pulse", kill_cnt, 1);

        do_reset();
        go(W'(3), W'(6));
        pulse_kill();
        chk("R9 kill wait-min", int'(state), S_STOP);
        chk("R9 kill wait-min end", end_cnt, 0);

        do_reset();
        go(W'(3), W'(6));
        restart(W'(3), W'(6));
        pulse_kill();
        chk("R9 kill update", int'(state), S_STOP);
        chk("R9 kill update pulse", kill_cnt, 1);

        do_reset();
        go(W'(0), W'(6));
        kill = 1'b1; trig = 1'b1;
        @(negedge clk);
        kill = 1'b0; trig = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 kill beats trig state", int'(state), S_STOP);
        chk("R9 kill beats trig end", end_cnt, 0);
        chk("R9 kill beats trig pulse", kill_cnt, 1);

        do_reset();
        go(W'(0), W'(6));
        pulse_trig();
        pulse_kill();
        chk("R9 kill done", int'(state), S_STOP);
        chk("R9 kill done pulse", kill_cnt, 1);
        pulse_kill();
        chk("R11 kill in stop", kill_cnt, 1);
        restart(W'(1), W'(2));
        repeat (3) @(negedge clk);
        chk("R11 start in stop", int'(state), S_STOP);

        finish_run();
    end
endmodule